// File: doc/BRIEF.md
# Multi-Channel Stream Start Gate

This block is the last gate on eight parallel sample streams before they reach the converter interfaces. Each channel has a valid/ready slave port facing upstream and a valid/ready master port facing the converter. A channel's gate either passes the stream through unchanged or holds it fully closed. A closed gate shows no valid beat downstream and no ready upstream, so no beat is lost or sent twice.

Gates are opened and closed by control bits, one per channel. A mode pin picks who drives them. In independent mode each channel follows its own bit, which software normally sets once that channel's buffer has been loaded. In synchronized mode every channel follows the bit of one master channel (parameter `MASTER_CH`, channel 0 by default). All gates then open on the same clock edge and the streams start together.

Control and mode are sampled once, by the per-channel gate register. A change takes effect after a single edge. A gate never closes while a beat it has offered is still waiting for ready. Back-pressure rules: while open, `s_tready[i]` equals `m_tready[i]` and `m_tvalid[i]` equals `s_tvalid[i]` in the same cycle. Upstream must hold a beat stable until it is accepted.

Top module: `stream_start_switch`

## Requirements
- R1: While reset is held and after it is released, before any control bit is applied, every gate is closed: `m_tvalid` and `s_tready` are all zero.
- R2: With `sync_mode`=0, the gate of channel i takes the value of `ch_ctrl[i]` sampled at a clock edge, and is in effect from that edge on.
- R3: An open gate passes `s_tdata`/`s_tvalid` to `m_tdata`/`m_tvalid` and `m_tready` back to `s_tready` in the same cycle. Channel i occupies bits [i*DATA_W +: DATA_W] of the data buses and bit i of the other buses.
- R4: A closed gate drives `m_tvalid[i]`=0 and `s_tready[i]`=0, whatever `s_tvalid[i]` and `m_tready[i]` are.
- R5: With `sync_mode`=1, every gate takes the value of `ch_ctrl[MASTER_CH]`, and the other control bits have no effect.
- R6: With `sync_mode`=1, when the master bit rises with all gates closed, all gates open on the same edge.
- R7: An open gate whose beat is offered and not accepted (`s_tvalid`=1, `m_tready`=0) at an edge stays open at that edge. It follows its control bit again at the first edge where no beat is pending.
- R8: A change of `sync_mode` takes effect at the next edge, with the same one-edge timing as a control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 0: independent control, 1: all channels follow the master bit |
| ch_ctrl | input | NUM_CH | Per-channel gate enable bits |
| s_tdata | input | NUM_CH*DATA_W | Upstream data, channel i at [i*DATA_W +: DATA_W] |
| s_tvalid | input | NUM_CH | Upstream valid |
| s_tready | output | NUM_CH | Ready to upstream |
| m_tdata | output | NUM_CH*DATA_W | Data toward the converters |
| m_tvalid | output | NUM_CH | Valid toward the converters |
| m_tready | input | NUM_CH | Ready from the converters |

## Verification
Control and mode changes are due one edge after they are driven. The bench drives them between edges, waits for one rising edge and samples one time unit later. Pass-through of data, valid and ready is combinational, so those checks sample in the same cycle as the stimulus. For the pending-beat hold, the bench first checks that the gate stays open across edges while ready is low. It then raises ready and checks that the gate closes at the very next edge.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_SYNC  = 1'b1
  } ssw_mode_e;
endpackage

// File: rtl/ssw_enable_select.sv
module ssw_enable_select
  import ssw_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int MASTER_CH = 0
) (
  input  logic              sync_mode,
  input  logic [NUM_CH-1:0] ch_ctrl,
  output logic [NUM_CH-1:0] req
);
  ssw_mode_e mode;
  assign mode = ssw_mode_e'(sync_mode);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_req
    // synchronized mode: master bit drives every channel
    assign req[i] = (mode == MODE_SYNC) ? ch_ctrl[MASTER_CH] : ch_ctrl[i];
  end
endmodule

// File: rtl/ssw_chan_gate.sv
module ssw_chan_gate #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              open_o
);
  logic open_q;
  logic pending;

  // a beat offered downstream but not yet taken pins the gate open
  assign pending = open_q & s_tvalid & ~m_tready;

  always_ff @(posedge clk) begin
    if (!rst_n)        open_q <= 1'b0;
    else if (!pending) open_q <= req_i;
  end

  assign m_tdata  = s_tdata;
  assign m_tvalid = open_q & s_tvalid;
  assign s_tready = open_q & m_tready;
  assign open_o   = open_q;

  // R7: gate stays open across an edge with an unaccepted beat
  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (open_q && m_tvalid));

  // R2: with nothing pending, the gate takes the requested value
  a_r2_follow_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_tvalid && !m_tready) |=> (open_q == $past(req_i)));

  // R4: no ready upstream without ready downstream
  a_r4_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tready |-> !s_tready);
endmodule

// File: rtl/stream_start_switch.sv
module stream_start_switch #(
  parameter int NUM_CH    = 8,
  parameter int DATA_W    = 16,
  parameter int MASTER_CH = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_mode,
  input  logic [NUM_CH-1:0]        ch_ctrl,
  input  logic [NUM_CH*DATA_W-1:0] s_tdata,
  input  logic [NUM_CH-1:0]        s_tvalid,
  output logic [NUM_CH-1:0]        s_tready,
  output logic [NUM_CH*DATA_W-1:0] m_tdata,
  output logic [NUM_CH-1:0]        m_tvalid,
  input  logic [NUM_CH-1:0]        m_tready
);
  localparam logic [NUM_CH-1:0] ALL_OPEN = '1;

  logic [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] open_vec;

  ssw_enable_select #(.NUM_CH(NUM_CH), .MASTER_CH(MASTER_CH)) sel_i (
    .sync_mode (sync_mode),
    .ch_ctrl   (ch_ctrl),
    .req       (req)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ssw_chan_gate #(.DATA_W(DATA_W)) gate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req[i]),
      .s_tdata  (s_tdata[i*DATA_W +: DATA_W]),
      .s_tvalid (s_tvalid[i]),
      .s_tready (s_tready[i]),
      .m_tdata  (m_tdata[i*DATA_W +: DATA_W]),
      .m_tvalid (m_tvalid[i]),
      .m_tready (m_tready[i]),
      .open_o   (open_vec[i])
    );
  end

  // R6: synchronized start opens every gate on one edge
  a_r6_sync_open_all: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ch_ctrl[MASTER_CH] && open_vec == '0) |=> (open_vec == ALL_OPEN));

  // R5: synchronized stop closes every gate with nothing pending
  a_r5_sync_close_all: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ch_ctrl[MASTER_CH] && (m_tvalid & ~m_tready) == '0) |=> (open_vec == '0));
endmodule

// File: tb/stream_start_switch_tb.sv
module stream_start_switch_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic [NCH-1:0] ch_ctrl = '0;
  logic [NCH*DW-1:0] s_tdata = '0;
  logic [NCH-1:0] s_tvalid = '0;
  logic [NCH-1:0] s_tready;
  logic [NCH*DW-1:0] m_tdata;
  logic [NCH-1:0] m_tvalid;
  logic [NCH-1:0] m_tready = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stream_start_switch #(.NUM_CH(NCH), .DATA_W(DW), .MASTER_CH(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ch_ctrl(ch_ctrl),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  task automatic chk8(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_data(input int tag);
    for (int c = 0; c < NCH; c++) s_tdata[c*DW +: DW] = DW'((c << 8) | (tag & 8'hff));
  endtask

  task automatic chk_data(input logic [NCH-1:0] open, input int tag);
    for (int c = 0; c < NCH; c++)
      if (open[c]) begin
        checks++;
        if (m_tdata[c*DW +: DW] !== DW'((c << 8) | (tag & 8'hff))) begin
          errors++;
          $display("FAIL R3: ch%0d data actual %h expected %h", c, m_tdata[c*DW +: DW],
                   DW'((c << 8) | (tag & 8'hff)));
        end
      end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    s_tvalid = '1;
    m_tready = '1;
    ch_ctrl  = '1;
    step(); step();
    // R1: closed during reset even with control and traffic present
    chk8("R1 valid in reset", m_tvalid, '0);
    chk8("R1 ready in reset", s_tready, '0);
    ch_ctrl = '0;
    rst_n = 1'b1;
    step();
    chk8("R1 valid after reset", m_tvalid, '0);
    chk8("R1 ready after reset", s_tready, '0);

    // R2/R3: independent mode sweep of every control pattern
    for (int p = 0; p < 256; p++) begin
      ch_ctrl = NCH'(p);
      set_data(p);
      step();
      chk8("R2 valid follows ctrl", m_tvalid, NCH'(p));
      chk8("R3 ready passthrough", s_tready, NCH'(p));
      chk_data(NCH'(p), p);
      // R4: closed gates ignore toggled handshakes; open ones pass them
      s_tvalid = 8'h55;
      m_tready = 8'hA5;
      #1;
      chk8("R4 valid gated", m_tvalid, NCH'(p) & 8'h55);
      chk8("R4 ready gated", s_tready, NCH'(p) & 8'hA5);
      s_tvalid = '1;
      m_tready = '1;
    end

    // R8/R5/R6: synchronized mode, other bits ignored
    ch_ctrl = '0;
    step();
    sync_mode = 1'b1;
    for (int p = 0; p < 256; p++) begin
      ch_ctrl = NCH'(p);
      step();
      chk8((p[0] ? "R6 all open together" : "R5 master closed"), m_tvalid,
           p[0] ? 8'hFF : 8'h00);
      chk8("R5 ready follows master", s_tready, p[0] ? 8'hFF : 8'h00);
    end

    // R8: back to independent mode, one-edge effect
    ch_ctrl = 8'h3C;
    step();
    chk8("R5 sync uses master bit", m_tvalid, 8'h00);
    sync_mode = 1'b0;
    step();
    chk8("R8 mode switch", m_tvalid, 8'h3C);

    // R7: pending beat holds gate open
    ch_ctrl = 8'h08;
    step();
    m_tready = 8'h00;
    ch_ctrl = 8'h00;
    step();
    chk8("R7 held open", m_tvalid, 8'h08);
    step();
    chk8("R7 still held", m_tvalid, 8'h08);
    m_tready = 8'h08;
    #1;
    chk8("R7 beat accepted", s_tready, 8'h08);
    step();
    chk8("R7 closes after accept", m_tvalid, 8'h00);
    chk8("R7 ready closed", s_tready, 8'h00);

    // R7: no pending beat when valid is low, so it closes at once
    m_tready = '1;
    ch_ctrl = 8'h01;
    step();
    s_tvalid = 8'h00;
    m_tready = 8'h00;
    ch_ctrl = 8'h00;
    step();
    s_tvalid = 8'h01;
    #1;
    chk8("R7 idle gate closes", m_tvalid, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule